// File: doc/BRIEF.md
# Aperture Page Remapping Unit

This block remaps addresses inside one fixed, contiguous aperture window onto physical memory, one 4 KiB page at a time. It keeps a single-level table with one 32-bit entry per aperture page. Each entry holds a valid flag and the physical frame address of its page. A lookup port accepts one address per clock. One clock later it returns the remapped physical address together with a hit flag and a fault flag.

Software reaches the table only through a small word-addressed register port. It writes the full aperture byte address of a page into an entry-pointer register. It then writes or reads the entry-data register to store or fetch the entry for that page. A control register turns translation on or off. The aperture base address and the number of pages are elaboration parameters.

Top module: `aperture_remap`

## Requirements
- R1: After reset the enable bit reads 0, every table entry reads back as zero, and the lookup outputs are all zero.
- R2: The control register sits at offset 0x24. A write stores bit 0 as the enable bit. A read returns the enable bit in bit 0 and zero in bits 31:1, and it always reflects the most recent write.
- R3: The entry-pointer register sits at offset 0x28. It holds a full 32-bit aperture byte address and reads back exactly as written.
- R4: The entry-data register sits at offset 0x2C. A write stores bit 31 as the valid flag and bits 30:12 as the frame address. A read of 0x2C returns the entry selected by the pointer, with bits 11:0 reading as zero.
- R5: If the entry pointer lies outside the aperture, writes to 0x2C change no entry and reads of 0x2C return zero.
- R6: A lookup that hits raises the hit flag one clock after the request, with fault low. The output address is {0, frame bits 30:12, input address bits 11:0}.
- R7: A lookup of an address below the base, or at or above base + page_count × 4096, raises fault with a zero output address.
- R8: A lookup whose selected entry has bit 31 clear raises fault with a zero output address.
- R9: While the enable bit is 0, every lookup faults with a zero output address. Setting it again restores hits.
- R10: Writing the value zero to an entry unmaps its page, so later lookups of that page fault.
- R11: A lookup issued in the same cycle as an entry write sees the old entry. Lookups from the next cycle on see the new entry.
- R12: In a cycle after one with no request, hit, fault and the output address are all zero.
- R13: The entry is chosen only by pointer bits above bit 11, so any byte address inside a page selects that page's entry.
- R14: The first byte of the aperture translates, and so does the last byte, base + page_count × 4096 − 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Register port word offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | 32 | Lookup input address |
| lk_hit | output | 1 | Lookup translated, one clock after the request |
| lk_fault | output | 1 | Lookup refused, one clock after the request |
| lk_paddr | output | 32 | Remapped physical address, zero unless hit |

## Verification
The bench builds the block with its base at 0x4800_0000 and only eight pages. With so few pages, both window edges and every entry can be reached in a few hundred cycles. A page count of eight also makes the index field exactly three bits wide. Out-of-window pointers then alias onto real entries: one page past the end maps to index 0, and one page below the base maps to index 7. That lets the bench show, through readback of those entries, that out-of-window writes truly leave them alone.

// File: rtl/aperture_remap_pkg.sv
package aperture_remap_pkg;
   localparam int PAGE_SHIFT = 12;
   localparam int WORD_W     = 32;
   localparam int VALID_POS  = 31;
   localparam int FRAME_W    = VALID_POS - PAGE_SHIFT;
   localparam int REG_OFS_W  = 8;

   localparam logic [REG_OFS_W-1:0] OFS_CTRL  = 8'h24;
   localparam logic [REG_OFS_W-1:0] OFS_EPTR  = 8'h28;
   localparam logic [REG_OFS_W-1:0] OFS_EDATA = 8'h2C;

   typedef struct packed {
      logic               valid;
      logic [FRAME_W-1:0] frame;
   } pte_t;

   function automatic pte_t word_to_pte(input logic [WORD_W-1:0] w);
      pte_t p;
      p.valid = w[VALID_POS];
      p.frame = w[VALID_POS-1:PAGE_SHIFT];
      return p;
   endfunction

   function automatic logic [WORD_W-1:0] pte_to_word(input pte_t p);
      return {p.valid, p.frame, {PAGE_SHIFT{1'b0}}};
   endfunction
endpackage

// File: rtl/aprm_window.sv
module aprm_window
   import aperture_remap_pkg::*;
#(
   parameter logic [31:0] BASE       = 32'h5800_0000,
   parameter int          PAGE_COUNT = 32,
   parameter int          IDX_W      = 5
) (
   input  logic [31:0]      addr,
   output logic             in_win,
   output logic [IDX_W-1:0] idx
);
   logic [32:0] rel;
   logic [32:0] page_num;

   generate
      if (BASE == 32'h0) begin : g_zero_base
         assign rel = {1'b0, addr};
      end else begin : g_offset_base
         assign rel = {1'b0, addr} - {1'b0, BASE};
      end
   endgenerate

   assign page_num = rel >> PAGE_SHIFT;
   assign in_win   = (addr >= BASE) && (page_num < 33'(PAGE_COUNT));
   assign idx      = page_num[IDX_W-1:0];
endmodule

// File: rtl/aprm_table.sv
module aprm_table
   import aperture_remap_pkg::*;
#(
   parameter int PAGE_COUNT = 32,
   parameter int IDX_W      = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             we,
   input  logic [IDX_W-1:0] widx,
   input  pte_t             wdata,
   input  logic [IDX_W-1:0] ridx_a,
   output pte_t             rdata_a,
   input  logic [IDX_W-1:0] ridx_b,
   output pte_t             rdata_b
);
   pte_t ent [PAGE_COUNT];

   generate
      for (genvar i = 0; i < PAGE_COUNT; i++) begin : g_ent
         pte_t q;
         always_ff @(posedge clk) begin
            if (rst)
               q <= '0;
            else if (we && (widx == IDX_W'(i)))
               q <= wdata;
         end
         assign ent[i] = q;
      end
   endgenerate

   always_comb begin
      rdata_a = '0;
      rdata_b = '0;
      for (int k = 0; k < PAGE_COUNT; k++) begin
         if (ridx_a == IDX_W'(k)) rdata_a = ent[k];
         if (ridx_b == IDX_W'(k)) rdata_b = ent[k];
      end
   end
endmodule

// File: rtl/aprm_regport.sv
module aprm_regport
   import aperture_remap_pkg::*;
#(
   parameter logic [31:0] BASE       = 32'h5800_0000,
   parameter int          PAGE_COUNT = 32,
   parameter int          IDX_W      = 5
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [REG_OFS_W-1:0] reg_addr,
   input  logic                 reg_wr,
   input  logic [WORD_W-1:0]    reg_wdata,
   output logic [WORD_W-1:0]    reg_rdata,
   input  pte_t                 sel_entry,
   output logic [IDX_W-1:0]     sel_idx,
   output logic                 ent_we,
   output pte_t                 ent_wdata,
   output logic                 cfg_en
);
   logic [WORD_W-1:0] eptr_q;
   logic              ptr_in_win;

   aprm_window #(.BASE(BASE), .PAGE_COUNT(PAGE_COUNT), .IDX_W(IDX_W)) u_ptr_win (
      .addr   (eptr_q),
      .in_win (ptr_in_win),
      .idx    (sel_idx)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         cfg_en <= 1'b0;
         eptr_q <= '0;
      end else if (reg_wr) begin
         if (reg_addr == OFS_CTRL) cfg_en <= reg_wdata[0];
         if (reg_addr == OFS_EPTR) eptr_q <= reg_wdata;
      end
   end

   assign ent_we    = reg_wr && (reg_addr == OFS_EDATA) && ptr_in_win;
   assign ent_wdata = word_to_pte(reg_wdata);

   always_comb begin
      unique case (reg_addr)
         OFS_CTRL:  reg_rdata = {{(WORD_W-1){1'b0}}, cfg_en};
         OFS_EPTR:  reg_rdata = eptr_q;
         OFS_EDATA: reg_rdata = ptr_in_win ? pte_to_word(sel_entry) : '0;
         default:   reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/aprm_lookup.sv
module aprm_lookup
   import aperture_remap_pkg::*;
#(
   parameter logic [31:0] BASE       = 32'h5800_0000,
   parameter int          PAGE_COUNT = 32,
   parameter int          IDX_W      = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cfg_en,
   input  logic              lk_req,
   input  logic [WORD_W-1:0] lk_addr,
   output logic [IDX_W-1:0]  tbl_idx,
   input  pte_t              tbl_entry,
   output logic              lk_hit,
   output logic              lk_fault,
   output logic [WORD_W-1:0] lk_paddr
);
   logic addr_in_win;
   logic hit_c;

   aprm_window #(.BASE(BASE), .PAGE_COUNT(PAGE_COUNT), .IDX_W(IDX_W)) u_lk_win (
      .addr   (lk_addr),
      .in_win (addr_in_win),
      .idx    (tbl_idx)
   );

   assign hit_c = lk_req && cfg_en && addr_in_win && tbl_entry.valid;

   always_ff @(posedge clk) begin
      if (rst) begin
         lk_hit   <= 1'b0;
         lk_fault <= 1'b0;
         lk_paddr <= '0;
      end else begin
         lk_hit   <= hit_c;
         lk_fault <= lk_req && !hit_c;
         lk_paddr <= hit_c ? {1'b0, tbl_entry.frame, lk_addr[PAGE_SHIFT-1:0]} : '0;
      end
   end
endmodule

// File: rtl/aperture_remap.sv
module aperture_remap
   import aperture_remap_pkg::*;
#(
   parameter logic [31:0] APERTURE_BASE = 32'h5800_0000,
   parameter int          PAGE_COUNT    = 32
) (
   input  logic        clk,
   input  logic        rst,
   input  logic [7:0]  reg_addr,
   input  logic        reg_wr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   input  logic        lk_req,
   input  logic [31:0] lk_addr,
   output logic        lk_hit,
   output logic        lk_fault,
   output logic [31:0] lk_paddr
);
   localparam int IDX_W = (PAGE_COUNT > 1) ? $clog2(PAGE_COUNT) : 1;

   generate
      if (APERTURE_BASE[PAGE_SHIFT-1:0] != '0) begin : g_bad_align
         $error("aperture base must be page aligned");
      end
      if (PAGE_COUNT < 1) begin : g_bad_count
         $error("page count must be at least one");
      end
      if ((64'(APERTURE_BASE) + 64'(PAGE_COUNT) * 64'd4096) > 64'h1_0000_0000) begin : g_bad_span
         $error("aperture must end within the 32-bit address space");
      end
   endgenerate

   logic             cfg_en;
   logic             ent_we;
   pte_t             ent_wdata;
   logic [IDX_W-1:0] sel_idx;
   pte_t             sel_entry;
   logic [IDX_W-1:0] lk_idx;
   pte_t             lk_entry;

   aprm_regport #(.BASE(APERTURE_BASE), .PAGE_COUNT(PAGE_COUNT), .IDX_W(IDX_W)) u_regs (
      .clk       (clk),
      .rst       (rst),
      .reg_addr  (reg_addr),
      .reg_wr    (reg_wr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .sel_entry (sel_entry),
      .sel_idx   (sel_idx),
      .ent_we    (ent_we),
      .ent_wdata (ent_wdata),
      .cfg_en    (cfg_en)
   );

   aprm_table #(.PAGE_COUNT(PAGE_COUNT), .IDX_W(IDX_W)) u_table (
      .clk     (clk),
      .rst     (rst),
      .we      (ent_we),
      .widx    (sel_idx),
      .wdata   (ent_wdata),
      .ridx_a  (sel_idx),
      .rdata_a (sel_entry),
      .ridx_b  (lk_idx),
      .rdata_b (lk_entry)
   );

   aprm_lookup #(.BASE(APERTURE_BASE), .PAGE_COUNT(PAGE_COUNT), .IDX_W(IDX_W)) u_lookup (
      .clk       (clk),
      .rst       (rst),
      .cfg_en    (cfg_en),
      .lk_req    (lk_req),
      .lk_addr   (lk_addr),
      .tbl_idx   (lk_idx),
      .tbl_entry (lk_entry),
      .lk_hit    (lk_hit),
      .lk_fault  (lk_fault),
      .lk_paddr  (lk_paddr)
   );
endmodule

// File: rtl/aprm_checker.sv
module aprm_checker #(
   parameter logic [31:0] BASE       = 32'h5800_0000,
   parameter int          PAGE_COUNT = 32
) (
   input logic        clk,
   input logic        rst,
   input logic [7:0]  reg_addr,
   input logic        reg_wr,
   input logic [31:0] reg_wdata,
   input logic        lk_req,
   input logic [31:0] lk_addr,
   input logic        lk_hit,
   input logic        lk_fault,
   input logic [31:0] lk_paddr,
   input logic        cfg_en
);
   logic outside;
   assign outside = (lk_addr < BASE) ||
                    (({1'b0, lk_addr} - {1'b0, BASE}) >= (33'(PAGE_COUNT) * 33'd4096));

   assert_hit_fault_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
      !(lk_hit && lk_fault));

   assert_hit_keeps_offset_R6: assert property (@(posedge clk) disable iff (rst)
      lk_req |=> (!lk_hit || (lk_paddr[11:0] == $past(lk_addr[11:0]))));

   assert_fault_zero_addr_R7: assert property (@(posedge clk) disable iff (rst)
      lk_fault |-> (lk_paddr == 32'h0));

   assert_outside_faults_R7: assert property (@(posedge clk) disable iff (rst)
      (lk_req && outside) |=> (lk_fault && !lk_hit));

   assert_disabled_no_hit_R9: assert property (@(posedge clk) disable iff (rst)
      (lk_req && !cfg_en) |=> !lk_hit);

   assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (rst)
      !lk_req |=> (!lk_hit && !lk_fault && (lk_paddr == 32'h0)));

   assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (rst)
      (reg_wr && (reg_addr == 8'h24)) |=> (cfg_en == $past(reg_wdata[0])));
endmodule

bind aperture_remap aprm_checker #(.BASE(APERTURE_BASE), .PAGE_COUNT(PAGE_COUNT)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .reg_addr  (reg_addr),
   .reg_wr    (reg_wr),
   .reg_wdata (reg_wdata),
   .lk_req    (lk_req),
   .lk_addr   (lk_addr),
   .lk_hit    (lk_hit),
   .lk_fault  (lk_fault),
   .lk_paddr  (lk_paddr),
   .cfg_en    (cfg_en)
);

// File: tb/tb_aperture_remap.sv
module tb_aperture_remap;
   localparam logic [31:0] BASE  = 32'h4800_0000;
   localparam int          PAGES = 8;
   localparam logic [7:0]  CTRL  = 8'h24;
   localparam logic [7:0]  EPTR  = 8'h28;
   localparam logic [7:0]  EDATA = 8'h2C;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [7:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        lk_req = 1'b0;
   logic [31:0] lk_addr = '0;
   logic        lk_hit;
   logic        lk_fault;
   logic [31:0] lk_paddr;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   aperture_remap #(.APERTURE_BASE(BASE), .PAGE_COUNT(PAGES)) dut (
      .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_req(lk_req),
      .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_fault(lk_fault), .lk_paddr(lk_paddr)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   function automatic logic [31:0] pg(input int p, input int ofs);
      return BASE + 32'(p) * 32'h1000 + 32'(ofs);
   endfunction

   task automatic map(input int p, input logic [31:0] d);
      wr(EPTR, pg(p, 0));
      wr(EDATA, d);
   endtask

   task automatic lookup(input string req, input logic [31:0] a, input logic eh,
                         input logic ef, input logic [31:0] ep);
      @(negedge clk);
      lk_req = 1'b1; lk_addr = a;
      @(negedge clk);
      lk_req = 1'b0;
      chk({req, " hit"},   {31'b0, lk_hit},   {31'b0, eh});
      chk({req, " fault"}, {31'b0, lk_fault}, {31'b0, ef});
      chk({req, " paddr"}, lk_paddr, ep);
   endtask

   task automatic t_reset;
      logic [31:0] v;
      rd(CTRL, v); chk("R1 ctrl", v, 32'h0);
      for (int p = 0; p < PAGES; p++) begin
         wr(EPTR, pg(p, 0));
         rd(EDATA, v); chk("R1 entry", v, 32'h0);
      end
      chk("R1 outputs", {lk_hit, lk_fault, 30'b0} | lk_paddr, 32'h0);
   endtask

   task automatic t_ctrl;
      logic [31:0] v;
      wr(CTRL, 32'h1);         rd(CTRL, v); chk("R2 set", v, 32'h1);
      wr(CTRL, 32'hFFFF_FFFE); rd(CTRL, v); chk("R2 clear", v, 32'h0);
      wr(CTRL, 32'h1);         rd(CTRL, v); chk("R2 reset", v, 32'h1);
   endtask

   task automatic t_ptr;
      logic [31:0] v;
      wr(EPTR, 32'hDEAD_B00F); rd(EPTR, v); chk("R3 readback", v, 32'hDEAD_B00F);
   endtask

   task automatic t_entry_rw;
      logic [31:0] v;
      map(2, 32'h8123_4ABC);
      rd(EDATA, v); chk("R4 readback", v, 32'h8123_4000);
      wr(EPTR, pg(2, 12'h7FF));
      rd(EDATA, v); chk("R13 mid-page ptr", v, 32'h8123_4000);
   endtask

   task automatic t_hit;
      lookup("R6 hit", pg(2, 12'h345), 1'b1, 1'b0, 32'h0123_4345);
   endtask

   task automatic t_boundary;
      map(7, 32'h8000_5000);
      map(0, 32'h8000_6000);
      lookup("R14 last byte", pg(PAGES, 0) - 32'h1, 1'b1, 1'b0, 32'h0000_5FFF);
      lookup("R14 first byte", BASE, 1'b1, 1'b0, 32'h0000_6000);
      lookup("R7 below", BASE - 32'h1, 1'b0, 1'b1, 32'h0);
      lookup("R7 above", pg(PAGES, 0), 1'b0, 1'b1, 32'h0);
   endtask

   task automatic t_ptr_outside;
      logic [31:0] v;
      wr(EPTR, pg(PAGES, 0));
      wr(EDATA, 32'h8777_7000);
      rd(EDATA, v); chk("R5 read above", v, 32'h0);
      wr(EPTR, BASE - 32'h1000);
      wr(EDATA, 32'h8777_7000);
      rd(EDATA, v); chk("R5 read below", v, 32'h0);
      wr(EPTR, pg(0, 0)); rd(EDATA, v); chk("R5 page0 intact", v, 32'h8000_6000);
      wr(EPTR, pg(7, 0)); rd(EDATA, v); chk("R5 page7 intact", v, 32'h8000_5000);
   endtask

   task automatic t_invalid;
      logic [31:0] v;
      lookup("R8 never mapped", pg(3, 4), 1'b0, 1'b1, 32'h0);
      map(4, 32'h0000_9000);
      rd(EDATA, v); chk("R8 readback", v, 32'h0000_9000);
      lookup("R8 valid clear", pg(4, 4), 1'b0, 1'b1, 32'h0);
   endtask

   task automatic t_unmap;
      logic [31:0] v;
      map(2, 32'h0);
      rd(EDATA, v); chk("R10 cleared", v, 32'h0);
      lookup("R10 unmapped", pg(2, 8), 1'b0, 1'b1, 32'h0);
   endtask

   task automatic t_disabled;
      map(2, 32'h8000_3000);
      wr(CTRL, 32'h0);
      lookup("R9 disabled", pg(2, 8), 1'b0, 1'b1, 32'h0);
      wr(CTRL, 32'h1);
      lookup("R9 reenabled", pg(2, 8), 1'b1, 1'b0, 32'h0000_3008);
   endtask

   task automatic t_same_cycle;
      wr(EPTR, pg(5, 0));
      @(negedge clk);
      reg_addr = EDATA; reg_wr = 1'b1; reg_wdata = 32'h8000_A000;
      lk_req = 1'b1; lk_addr = pg(5, 12'h10);
      @(negedge clk);
      reg_wr = 1'b0;
      chk("R11 old entry fault", {31'b0, lk_fault}, 32'h1);
      chk("R11 old entry paddr", lk_paddr, 32'h0);
      @(negedge clk);
      lk_req = 1'b0;
      chk("R11 new entry hit", {31'b0, lk_hit}, 32'h1);
      chk("R11 new entry paddr", lk_paddr, 32'h0000_A010);
   endtask

   task automatic t_idle;
      lookup("R12 prior", pg(9, 0), 1'b0, 1'b1, 32'h0);
      @(negedge clk);
      chk("R12 idle hit",   {31'b0, lk_hit},   32'h0);
      chk("R12 idle fault", {31'b0, lk_fault}, 32'h0);
      chk("R12 idle paddr", lk_paddr, 32'h0);
   endtask

   task automatic finish_run;
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst = 1'b0;
      t_reset;
      t_ctrl;
      t_ptr;
      t_entry_rw;
      t_hit;
      t_boundary;
      t_ptr_outside;
      t_invalid;
      t_unmap;
      t_disabled;
      t_same_cycle;
      t_idle;
      finish_run;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run;
   end
endmodule